// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block makes the hazard and forwarding decisions for a five-stage in-order pipeline: fetch with PC increment, decode with register read, execute, memory access and writeback. Each cycle it takes the decoded fields of the instruction in decode. It keeps its own registered copy of the control fields of the instructions in execute, memory and writeback. From these it produces the operand source selects for the execute stage, a hold signal for the PC and the fetch/decode latch, and a bubble signal for the decode/execute latch. It also produces a PC redirect, with a flush of the fetch slot, for branches that have one delay slot.

The register file writes in the first half of a cycle and reads in the second. A producer in writeback therefore reaches a reader in decode with no help from this block. Results in the execute/memory latch or the memory/writeback latch are forwarded to the operands of the instruction in execute. A load whose result is needed by the instruction right behind it costs exactly one bubble. The branch outcome is supplied from the execute stage. When it is true, the PC is redirected. The instruction directly after the branch always completes, and only the sequential fetch behind that slot is flushed.

The controller has three states, held in a small state machine. ST_RUN is normal flow. ST_BUBBLE is entered on a load-use stall and means a bubble now occupies execute. ST_SLOT is entered on a taken branch and means the delay slot now occupies execute. The transitions are as follows. Any state goes to ST_BUBBLE when stall is raised. Any state goes to ST_SLOT when pc_redirect is raised. Any state goes to ST_RUN otherwise. In ST_SLOT a branch sitting in the delay slot is not allowed to redirect.

Top module: `hz_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, fwd_a, fwd_b, stall, bubble, pc_redirect, fetch_flush, ex_wr_en, ex_mem_rd and ex_mem_wr are all 0.
- R2: When an operand register of the instruction in execute equals the destination of the writing instruction one stage ahead (execute/memory latch), that operand's select is 2'b10. This holds even if the writeback-side instruction also matches.
- R3: When only the instruction two stages ahead (memory/writeback latch) writes the operand register, the select is 2'b01. A producer three or more stages ahead gives 2'b00, which means the register file value.
- R4: When the instruction in execute is a writing load and the decode instruction reads its destination, stall and bubble are 1 for exactly that one cycle. The dependent instruction is then presented again, and its operand is served with select 2'b01.
- R5: In the cycle after a bubble is inserted, ex_wr_en, ex_mem_rd and ex_mem_wr are all 0.
- R6: Register 0 is never forwarded and never causes a stall. An instruction with its write enable low (for example a store) is never forwarded from and never causes a stall.
- R7: When a branch is in execute and ex_cond is 1, pc_redirect and fetch_flush are 1 in that cycle. The delay-slot instruction held in decode still moves to execute on the next edge.
- R8: A branch in execute with ex_cond 0 gives pc_redirect 0 and fetch_flush 0.
- R9: A load followed by one independent instruction and then a user of the load gives no stall, and the user's select is 2'b01.
- R10: A branch in the delay slot of a taken branch does not redirect, even with ex_cond 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| id_valid | input | 1 | Decode stage holds an instruction |
| id_rs | input | 5 | First source register of decode instruction |
| id_rt | input | 5 | Second source register of decode instruction |
| id_rd | input | 5 | Destination register of decode instruction |
| id_wr | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store |
| id_branch | input | 1 | Decode instruction is a branch |
| ex_cond | input | 1 | Branch comparison result from execute |
| fwd_a | output | 2 | First operand select: 00 register file, 01 memory/writeback, 10 execute/memory |
| fwd_b | output | 2 | Second operand select, same coding |
| stall | output | 1 | Hold PC and fetch/decode latch |
| bubble | output | 1 | Load bubble into decode/execute latch |
| pc_redirect | output | 1 | Load branch target into PC |
| fetch_flush | output | 1 | Discard the fetched instruction behind the delay slot |
| ex_wr_en | output | 1 | Register write enable held in decode/execute latch |
| ex_mem_rd | output | 1 | Memory read enable held in decode/execute latch |
| ex_mem_wr | output | 1 | Memory write enable held in decode/execute latch |

## Verification
The patterns used are these:
- Back-to-back ALU chains. These separate a producer one stage ahead from one two stages ahead. They also separate both from one three ahead that needs no forward, and they check that the nearer producer wins.
- A load with an immediate user, and a load with one independent instruction in between. These separate the one-bubble case from the forward-only case.
- Writes to register 0, and a store whose destination field matches a later source. These show that neither forwards nor stalls.
- A taken branch, a not-taken branch, and a taken branch with a branch in its slot. These separate redirect timing, the kept delay slot and the blocked second redirect.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int unsigned HZ_RAW = 5;

    typedef struct packed {
        logic              v;
        logic [HZ_RAW-1:0] rs;
        logic [HZ_RAW-1:0] rt;
        logic [HZ_RAW-1:0] rd;
        logic              wr;
        logic              ld;
        logic              st;
        logic              br;
    } hz_slot_t;

    typedef struct packed {
        logic              wr;
        logic [HZ_RAW-1:0] rd;
    } hz_dst_t;

    typedef enum logic [1:0] {
        FW_RF  = 2'b00,
        FW_WB  = 2'b01,
        FW_MEM = 2'b10
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_BUBBLE,
        ST_SLOT
    } hz_state_e;
endpackage

// File: rtl/hz_track.sv
module hz_track
    import hz_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  hz_slot_t id_slot,
    input  logic     insert_bubble,
    output hz_slot_t ex_slot,
    output hz_dst_t  mem_dst,
    output hz_dst_t  wb_dst
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ex_slot <= '0;
            mem_dst <= '0;
            wb_dst  <= '0;
        end else begin
            ex_slot    <= insert_bubble ? '0 : id_slot;
            mem_dst.wr <= ex_slot.v & ex_slot.wr;
            mem_dst.rd <= ex_slot.rd;
            wb_dst     <= mem_dst;
        end
    end

    // R5: a bubble leaves no write or memory enable in the execute slot
    p_bubble_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        insert_bubble |=> (!ex_slot.wr && !ex_slot.ld && !ex_slot.st));
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int unsigned RAW = HZ_RAW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] src,
    input  hz_dst_t        mem_dst,
    input  hz_dst_t        wb_dst,
    output fwd_sel_e       sel
);
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        mem_hit = mem_dst.wr && (mem_dst.rd != '0) && (mem_dst.rd == src);
        wb_hit  = wb_dst.wr  && (wb_dst.rd  != '0) && (wb_dst.rd  == src);
        if (mem_hit)     sel = FW_MEM;
        else if (wb_hit) sel = FW_WB;
        else             sel = FW_RF;
    end

    // R6: register 0 always reads from the register file
    p_zero_no_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == FW_RF));
    // R2: a nearer matching writer always wins
    p_near_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_dst.wr && src != '0 && mem_dst.rd == src) |-> (sel == FW_MEM));
endmodule

// File: rtl/hz_stall_unit.sv
module hz_stall_unit
    import hz_pkg::*;
(
    input  hz_slot_t id_slot,
    input  hz_slot_t ex_slot,
    output logic     load_use
);
    logic reads_dst;

    always_comb begin
        reads_dst = (ex_slot.rd == id_slot.rs) || (ex_slot.rd == id_slot.rt);
        load_use  = id_slot.v && ex_slot.v && ex_slot.ld && ex_slot.wr &&
                    (ex_slot.rd != '0) && reads_dst;
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned RAW     = HZ_RAW,
    parameter int unsigned NUM_SRC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           id_valid,
    input  logic [RAW-1:0] id_rs,
    input  logic [RAW-1:0] id_rt,
    input  logic [RAW-1:0] id_rd,
    input  logic           id_wr,
    input  logic           id_load,
    input  logic           id_store,
    input  logic           id_branch,
    input  logic           ex_cond,
    output logic [1:0]     fwd_a,
    output logic [1:0]     fwd_b,
    output logic           stall,
    output logic           bubble,
    output logic           pc_redirect,
    output logic           fetch_flush,
    output logic           ex_wr_en,
    output logic           ex_mem_rd,
    output logic           ex_mem_wr
);
    hz_slot_t  id_slot;
    hz_slot_t  ex_slot;
    hz_dst_t   mem_dst;
    hz_dst_t   wb_dst;
    logic      load_use;
    logic      take_raw;
    hz_state_e state_q;
    hz_state_e state_d;
    logic [RAW-1:0] src_vec [NUM_SRC];
    fwd_sel_e       sel_vec [NUM_SRC];

    always_comb begin
        id_slot = '0;
        if (id_valid) begin
            id_slot.v  = 1'b1;
            id_slot.rs = id_rs;
            id_slot.rt = id_rt;
            id_slot.rd = id_rd;
            id_slot.wr = id_wr;
            id_slot.ld = id_load;
            id_slot.st = id_store;
            id_slot.br = id_branch;
        end
    end

    hz_track u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .id_slot       (id_slot),
        .insert_bubble (bubble),
        .ex_slot       (ex_slot),
        .mem_dst       (mem_dst),
        .wb_dst        (wb_dst)
    );

    hz_stall_unit u_stall (
        .id_slot  (id_slot),
        .ex_slot  (ex_slot),
        .load_use (load_use)
    );

    always_comb begin
        src_vec[0] = ex_slot.v ? ex_slot.rs : '0;
        src_vec[1] = ex_slot.v ? ex_slot.rt : '0;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_fwd
        hz_fwd_unit #(.RAW(RAW)) u_fwd (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (src_vec[g]),
            .mem_dst (mem_dst),
            .wb_dst  (wb_dst),
            .sel     (sel_vec[g])
        );
    end

    assign fwd_a     = sel_vec[0];
    assign fwd_b     = sel_vec[1];
    assign ex_wr_en  = ex_slot.v & ex_slot.wr;
    assign ex_mem_rd = ex_slot.v & ex_slot.ld;
    assign ex_mem_wr = ex_slot.v & ex_slot.st;
    assign take_raw  = ex_slot.v & ex_slot.br & ex_cond;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // outputs and next state
    always_comb begin
        stall       = 1'b0;
        pc_redirect = 1'b0;
        unique case (state_q)
            ST_RUN, ST_BUBBLE: begin
                stall       = load_use;
                pc_redirect = take_raw;
            end
            ST_SLOT: begin
                stall       = load_use;
                pc_redirect = 1'b0;
            end
            default: begin
                stall       = 1'b0;
                pc_redirect = 1'b0;
            end
        endcase
        bubble      = stall;
        fetch_flush = pc_redirect;
        if (stall)            state_d = ST_BUBBLE;
        else if (pc_redirect) state_d = ST_SLOT;
        else                  state_d = ST_RUN;
    end

    // R4: one load-use bubble never needs a second
    p_one_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    // R4: a stall and a redirect never share a cycle
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |-> !stall);
    // R7: the delay slot reaches execute after a redirect
    p_slot_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_redirect && id_valid) |=> ex_slot.v);
    // R10: no redirect from the delay slot of a taken branch
    p_no_double_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_redirect |=> !pc_redirect);
endmodule

// File: tb/sim_hz_ctrl.sv
`timescale 1ns/1ps
module sim_hz_ctrl;
    import hz_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid = 1'b0, id_wr = 1'b0, id_load = 1'b0, id_store = 1'b0, id_branch = 1'b0;
    logic [4:0] id_rs = '0, id_rt = '0, id_rd = '0;
    logic ex_cond = 1'b0;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble, pc_redirect, fetch_flush, ex_wr_en, ex_mem_rd, ex_mem_wr;

    always #2.5 clk = ~clk;

    hz_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs(id_rs), .id_rt(id_rt),
        .id_rd(id_rd), .id_wr(id_wr), .id_load(id_load), .id_store(id_store),
        .id_branch(id_branch), .ex_cond(ex_cond), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .stall(stall), .bubble(bubble), .pc_redirect(pc_redirect),
        .fetch_flush(fetch_flush), .ex_wr_en(ex_wr_en), .ex_mem_rd(ex_mem_rd),
        .ex_mem_wr(ex_mem_wr)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    localparam int N = 25;
    hz_slot_t prog [N];
    bit       cnd  [N];
    hz_slot_t m_ex, m_mem, m_wb, cur;
    bit       m_ex_cond;
    bit       prev_take;

    task automatic chk(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic hz_slot_t mk(int rs, int rt, int rd, bit wr, bit ld, bit st, bit br);
        hz_slot_t s;
        s.v = 1'b1; s.rs = 5'(rs); s.rt = 5'(rt); s.rd = 5'(rd);
        s.wr = wr; s.ld = ld; s.st = st; s.br = br;
        return s;
    endfunction

    function automatic int exp_sel(logic [4:0] r);
        if (!m_ex.v || r == 0) return 0;
        if (m_mem.v && m_mem.wr && m_mem.rd == r) return 2;
        if (m_wb.v && m_wb.wr && m_wb.rd == r) return 1;
        return 0;
    endfunction

    task automatic drive(input hz_slot_t s, input bit c);
        id_valid = s.v; id_rs = s.rs; id_rt = s.rt; id_rd = s.rd;
        id_wr = s.wr; id_load = s.ld; id_store = s.st; id_branch = s.br;
        ex_cond = c;
    endtask

    initial begin
        #200000;
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int ptr = 0;
        bit flush_pend = 1'b0;
        bit e_stall, e_take;
        for (int i = 0; i < N; i++) cnd[i] = 1'b0;
        prog[0]  = mk(1, 2, 3, 1, 0, 0, 0);   // r3 = r1 op r2
        prog[1]  = mk(3, 3, 4, 1, 0, 0, 0);   // both from one ahead (R2)
        prog[2]  = mk(3, 4, 5, 1, 0, 0, 0);   // r3 two ahead, r4 one ahead (R3)
        prog[3]  = mk(3, 0, 6, 1, 0, 0, 0);   // r3 three ahead -> regfile (R3)
        prog[4]  = mk(1, 0, 7, 1, 1, 0, 0);   // load r7
        prog[5]  = mk(7, 2, 8, 1, 0, 0, 0);   // load-use (R4)
        prog[6]  = mk(1, 0, 9, 1, 1, 0, 0);   // load r9
        prog[7]  = mk(1, 2, 10, 1, 0, 0, 0);  // independent
        prog[8]  = mk(9, 0, 11, 1, 0, 0, 0);  // user after gap (R9)
        prog[9]  = mk(1, 1, 0, 1, 0, 0, 0);   // writes r0
        prog[10] = mk(0, 0, 12, 1, 0, 0, 0);  // reads r0 (R6)
        prog[11] = mk(1, 0, 0, 1, 1, 0, 0);   // load to r0
        prog[12] = mk(0, 1, 13, 1, 0, 0, 0);  // no stall on r0 (R6)
        prog[13] = mk(1, 5, 14, 0, 0, 1, 0);  // store, rd field 14, no write
        prog[14] = mk(14, 14, 15, 1, 0, 0, 0);// no forward from store (R6)
        prog[15] = mk(1, 2, 0, 0, 0, 0, 1); cnd[15] = 1'b1; // taken (R7)
        prog[16] = mk(1, 2, 16, 1, 0, 0, 0);  // delay slot
        prog[17] = mk(16, 16, 17, 1, 0, 0, 0);// killed fetch
        prog[18] = mk(16, 1, 18, 1, 0, 0, 0); // target, r16 two ahead
        prog[19] = mk(1, 2, 0, 0, 0, 0, 1); cnd[19] = 1'b0; // not taken (R8)
        prog[20] = mk(18, 2, 19, 1, 0, 0, 0); // slot
        prog[21] = mk(19, 1, 20, 1, 0, 0, 0); // sequential, kept
        prog[22] = mk(1, 2, 0, 0, 0, 0, 1); cnd[22] = 1'b1; // taken (R10)
        prog[23] = mk(1, 2, 0, 0, 0, 0, 1); cnd[23] = 1'b1; // branch in slot
        prog[24] = mk(3, 3, 21, 1, 0, 0, 0);  // killed fetch

        m_ex = '0; m_mem = '0; m_wb = '0; prev_take = 1'b0;
        drive('0, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 stall in reset", int'(stall), 0);
        chk("R1 fwd_a in reset", int'(fwd_a), 0);
        chk("R1 redirect in reset", int'(pc_redirect), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 ex controls after reset", int'({ex_wr_en, ex_mem_rd, ex_mem_wr}), 0);
        chk("R1 fwd_b after reset", int'(fwd_b), 0);
        chk("R1 flush after reset", int'(fetch_flush), 0);

        for (int cyc = 0; cyc < 60; cyc++) begin
            @(negedge clk);
            if (flush_pend || ptr >= N) cur = '0;
            else cur = prog[ptr];
            m_ex_cond = (m_ex.v && m_ex.br) ? cnd_of_ex() : 1'b0;
            drive(cur, m_ex_cond);
            #1;
            e_stall = cur.v && m_ex.v && m_ex.ld && m_ex.wr && m_ex.rd != 0 &&
                      (m_ex.rd == cur.rs || m_ex.rd == cur.rt);
            e_take  = m_ex.v && m_ex.br && m_ex_cond && !prev_take;
            chk("R2 R3 R6 R9 fwd_a", int'(fwd_a), exp_sel(m_ex.rs));
            chk("R2 R3 R6 R9 fwd_b", int'(fwd_b), exp_sel(m_ex.rt));
            chk("R4 R6 R9 stall", int'(stall), int'(e_stall));
            chk("R4 bubble", int'(bubble), int'(e_stall));
            chk("R7 R8 R10 redirect", int'(pc_redirect), int'(e_take));
            chk("R7 R8 R10 flush", int'(fetch_flush), int'(e_take));
            chk("R5 ex controls", int'({ex_wr_en, ex_mem_rd, ex_mem_wr}),
                int'({m_ex.v & m_ex.wr, m_ex.v & m_ex.ld, m_ex.v & m_ex.st}));
            // model advance at the edge
            m_wb = m_mem; m_mem = m_ex;
            m_ex = e_stall ? hz_slot_t'('0) : cur;
            if (e_stall) ex_idx_hold();
            else ex_idx_take(flush_pend, ptr);
            prev_take = e_take;
            if (flush_pend) flush_pend = 1'b0;
            else if (e_take) begin ptr = ptr + 2; flush_pend = 1'b1; end
            else if (!e_stall && ptr < N) ptr = ptr + 1;
        end
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // tracks which program entry is in the model's execute slot
    int ex_idx = -1;
    function automatic bit cnd_of_ex();
        if (ex_idx < 0 || ex_idx >= N) return 1'b0;
        return cnd[ex_idx];
    endfunction
    task automatic ex_idx_hold();
        ex_idx = -1;
    endtask
    task automatic ex_idx_take(input bit was_flush, input int p);
        if (was_flush || p >= N) ex_idx = -1;
        else ex_idx = p;
    endtask
endmodule